// File: doc/BRIEF.md
# Privileged flag-clear unit

This block watches an instruction byte stream, one byte per cycle, and picks out the three-byte opcode 0x0F 0x01 0xCA of the instruction that clears the alignment-check flag. Along with the bytes it receives the prefix indications for the instruction (a LOCK prefix and any mandatory 66/F2/F3 prefix), the current privilege level, the processor mode and the enable bit for supervisor-mode access prevention. It holds the 32-bit flags register itself. A separate write port loads that register.

When the third opcode byte is accepted, the block checks whether the instruction is legal in the current context. If it is, the block clears the alignment-check bit (bit 18) and gives a one-cycle retire pulse. If it is not, the block gives a one-cycle invalid-opcode fault pulse and leaves the flags untouched. The privilege rule depends on the mode. Real mode skips it. Protected, compatibility and 64-bit modes enforce it. Virtual-8086 mode always faults.

Top module: `flagclr_unit`

## Requirements
- R1: The match fires only when the accepted bytes (cycles with `byte_valid` high) end in 0x0F, 0x01, 0xCA. Idle cycles keep the partial match. A mismatching byte drops the match, unless that byte is 0x0F, which restarts it at the first-byte stage. Prefixes, privilege, mode and feature bit are sampled in the cycle of the 0xCA byte, and the outcome pulse appears in the following cycle.
- R2: A legal instruction clears bit 18 of `flags_q` on the same edge that raises `retire`. All other bits keep their values.
- R3: When `pfx_mand` is high and the mode is not virtual-8086, the sequence is a different instruction: no retire, no fault, and the flags are unchanged.
- R4: When `pfx_lock` is high, the instruction faults in every mode.
- R5: Mode codes 1 (protected), 3 (compatibility) and 4 (64-bit) fault when `cpl` is not 0.
- R6: Mode code 0 (real) ignores `cpl`. Only the LOCK and feature checks apply there.
- R7: Mode code 2 (virtual-8086) always faults on the sequence, whatever the prefixes, privilege or feature bit.
- R8: When `feat_en` is 0, the instruction faults.
- R9: Each matched instruction gives at most one pulse, `retire` or `fault`, never both, and lasting one cycle. Several fault causes together still give a single fault pulse. A fault never changes the flags.
- R10: After reset, `flags_q` is 0x00000002. When `flags_we` is high, `flags_wdata` is loaded at the next edge. If a clear lands on the same edge, the loaded value is taken with bit 18 forced to 0.
- R11: The unused mode codes 5, 6 and 7 fault on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_valid | input | 1 | `byte_in` carries an instruction byte this cycle |
| byte_in | input | 8 | Instruction byte |
| pfx_lock | input | 1 | LOCK prefix attached to the instruction |
| pfx_mand | input | 1 | A 66/F2/F3 mandatory prefix is attached |
| cpl | input | 2 | Current privilege level |
| cpu_mode | input | 3 | 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| feat_en | input | 1 | Access-prevention feature bit (bit 20 of the structured feature word) |
| flags_we | input | 1 | Load `flags_wdata` into the flags register |
| flags_wdata | input | 32 | Flags load value |
| flags_q | output | 32 | Flags register |
| retire | output | 1 | One-cycle pulse: instruction completed, AC cleared |
| fault | output | 1 | One-cycle pulse: invalid-opcode fault |

## Verification
The hardest cases to reach from the ports are partial matches that overlap, where a repeated 0x0F or a stray 0x01 has to restart the match or break it, and a flags write that lands on the very edge where the clear happens. The stimulus builds byte streams on purpose with doubled escape bytes, interleaved idle cycles and broken sequences. It also drives `flags_we` in the same cycle as the 0xCA byte, once for a retiring instruction and once for a faulting one. A behavioural model keeps the last three accepted bytes in a queue and is compared with the outputs on every clock.

// File: rtl/flagclr_pkg.sv
package flagclr_pkg;

  // Processor mode codes as presented on cpu_mode
  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_PROT   = 3'd1,
    MODE_V86    = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpu_mode_e;

  // Opcode matcher progress
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ESC  = 2'd1,
    MS_GRP  = 2'd2
  } match_state_e;

  // Context sampled together with the final opcode byte
  typedef struct packed {
    logic       lock;
    logic       mand;
    logic [1:0] cpl;
    logic [2:0] mode;
    logic       feat;
  } insn_ctx_t;

endpackage

// File: rtl/flagclr_matcher.sv
module flagclr_matcher
  import flagclr_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter logic [BYTE_W-1:0] OPC0 = 8'h0F,
  parameter logic [BYTE_W-1:0] OPC1 = 8'h01,
  parameter logic [BYTE_W-1:0] OPC2 = 8'hCA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              hit
);

  match_state_e state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    if (byte_valid) begin
      unique case (state_q)
        MS_IDLE: state_d = (byte_in == OPC0) ? MS_ESC : MS_IDLE;
        MS_ESC: begin
          if (byte_in == OPC1)      state_d = MS_GRP;
          else if (byte_in == OPC0) state_d = MS_ESC;
          else                      state_d = MS_IDLE;
        end
        MS_GRP:  state_d = (byte_in == OPC0) ? MS_ESC : MS_IDLE;
        default: state_d = MS_IDLE;
      endcase
    end
  end

  // register process with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= MS_IDLE;
    else if (byte_valid) state_q <= state_d;
  end

  assign hit = byte_valid && (state_q == MS_GRP) && (byte_in == OPC2);

endmodule

// File: rtl/flagclr_legality.sv
module flagclr_legality
  import flagclr_pkg::*;
(
  input  insn_ctx_t ctx,
  output logic      recog,
  output logic      fault
);

  logic is_v86, priv_mode, bad_mode, priv_fail;

  always_comb begin
    is_v86    = (ctx.mode == MODE_V86);
    priv_mode = (ctx.mode == MODE_PROT) || (ctx.mode == MODE_COMPAT) ||
                (ctx.mode == MODE_LONG);
    bad_mode  = (ctx.mode > MODE_LONG);
    priv_fail = priv_mode && (ctx.cpl != 2'd0);
    // a mandatory prefix turns the bytes into another instruction,
    // except in virtual-8086 mode where the sequence always traps
    recog     = is_v86 || !ctx.mand;
    fault     = recog && (ctx.lock || !ctx.feat || is_v86 || bad_mode || priv_fail);
  end

endmodule

// File: rtl/flagclr_flags_reg.sv
module flagclr_flags_reg #(
  parameter int             W       = 32,
  parameter int             AC_BIT  = 18,
  parameter logic [W-1:0]   RST_VAL = 32'h0000_0002
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         clr_ac,
  output logic [W-1:0] q
);

  logic [W-1:0] d;
  logic         en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == AC_BIT) begin : g_ac
      assign d[i] = clr_ac ? 1'b0 : (we ? wdata[i] : q[i]);
    end else begin : g_plain
      assign d[i] = we ? wdata[i] : q[i];
    end
  end

  assign en = we || clr_ac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (en) q <= d;
  end

endmodule

// File: rtl/flagclr_unit.sv
module flagclr_unit
  import flagclr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int AC_BIT  = 18,
  parameter logic [DATA_W-1:0] FLAGS_RST = 32'h0000_0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              pfx_lock,
  input  logic              pfx_mand,
  input  logic [1:0]        cpl,
  input  logic [2:0]        cpu_mode,
  input  logic              feat_en,
  input  logic              flags_we,
  input  logic [DATA_W-1:0] flags_wdata,
  output logic [DATA_W-1:0] flags_q,
  output logic              retire,
  output logic              fault
);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic      hit, recog, bad;
  insn_ctx_t ctx;
  logic      retire_d, fault_d;

  flagclr_matcher #(.BYTE_W(BYTE_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .byte_valid (byte_valid),
    .byte_in    (byte_in),
    .hit        (hit)
  );

  always_comb begin
    ctx.lock = pfx_lock;
    ctx.mand = pfx_mand;
    ctx.cpl  = cpl;
    ctx.mode = cpu_mode;
    ctx.feat = feat_en;
  end

  flagclr_legality u_legal (
    .ctx   (ctx),
    .recog (recog),
    .fault (bad)
  );

  // outcome next-state
  always_comb begin
    retire_d = hit && recog && !bad;
    fault_d  = hit && recog && bad;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      retire <= 1'b0;
      fault  <= 1'b0;
    end else begin
      retire <= retire_d;
      fault  <= fault_d;
    end
  end

  flagclr_flags_reg #(.W(DATA_W), .AC_BIT(AC_BIT), .RST_VAL(FLAGS_RST)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (flags_we),
    .wdata  (flags_wdata),
    .clr_ac (retire_d),
    .q      (flags_q)
  );

endmodule

// File: rtl/flagclr_checker.sv
module flagclr_checker
  import flagclr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int AC_BIT = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic [BYTE_W-1:0] byte_in,
  input logic              pfx_lock,
  input logic [1:0]        cpl,
  input logic [2:0]        cpu_mode,
  input logic              feat_en,
  input logic              flags_we,
  input logic [DATA_W-1:0] flags_q,
  input logic              retire,
  input logic              fault
);

  // R9: never both pulses
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire && fault));

  // R2: a retire is always accompanied by a cleared AC bit
  assert_ac_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> !flags_q[AC_BIT]);

  // R1: a retire follows an accepted final opcode byte
  assert_final_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(byte_valid && (byte_in == 8'hCA)));

  // R4 / R8: no retire under a LOCK prefix or with the feature off
  assert_lock_feat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(!pfx_lock && feat_en));

  // R7: no retire in virtual-8086 mode
  assert_no_v86_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> $past(cpu_mode != MODE_V86));

  // R5: privileged modes retire only at level 0
  assert_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && $past(cpu_mode == MODE_PROT || cpu_mode == MODE_COMPAT ||
                     cpu_mode == MODE_LONG)) |-> $past(cpl == 2'd0));

  // R9 / R10: flags change only through a write or a retire
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !$past(flags_we)) |-> $stable(flags_q));

endmodule

bind flagclr_unit flagclr_checker #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .AC_BIT (AC_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .byte_valid (byte_valid),
  .byte_in    (byte_in),
  .pfx_lock   (pfx_lock),
  .cpl        (cpl),
  .cpu_mode   (cpu_mode),
  .feat_en    (feat_en),
  .flags_we   (flags_we),
  .flags_q    (flags_q),
  .retire     (retire),
  .fault      (fault)
);

// File: tb/flagclr_unit_tb.sv
`timescale 1ns/1ps
module flagclr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        pfx_lock = 1'b0;
  logic        pfx_mand = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic [2:0]  cpu_mode = 3'd0;
  logic        feat_en = 1'b1;
  logic        flags_we = 1'b0;
  logic [31:0] flags_wdata = 32'h0;
  logic [31:0] flags_q;
  logic        retire, fault;

  always #4 clk = ~clk;  // 125 MHz

  flagclr_unit u_dut (
    .clk (clk), .rst_n (rst_n), .byte_valid (byte_valid), .byte_in (byte_in),
    .pfx_lock (pfx_lock), .pfx_mand (pfx_mand), .cpl (cpl), .cpu_mode (cpu_mode),
    .feat_en (feat_en), .flags_we (flags_we), .flags_wdata (flags_wdata),
    .flags_q (flags_q), .retire (retire), .fault (fault)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R10";
  bit    done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_flags = 32'h0000_0002;
  bit          m_ret = 0, m_flt = 0;
  int          rel_cnt = 0;
  logic [7:0]  hist[$];

  always @(posedge clk) begin
    bit matched, is_this, bad;
    logic [31:0] nf;
    if (!rst_n || rel_cnt < 2) begin
      if (!rst_n) rel_cnt = 0; else rel_cnt++;
      m_flags = 32'h0000_0002; m_ret = 0; m_flt = 0;
      hist.delete();
    end else begin
      matched = 0;
      if (byte_valid) begin
        hist.push_back(byte_in);
        if (hist.size() > 3) void'(hist.pop_front());
        matched = (hist.size() == 3) && hist[0] == 8'h0F && hist[1] == 8'h01 && hist[2] == 8'hCA;
      end
      is_this = (cpu_mode == 3'd2) || !pfx_mand;
      case (cpu_mode)
        3'd0:                bad = pfx_lock || !feat_en;
        3'd1, 3'd3, 3'd4:    bad = pfx_lock || !feat_en || (cpl != 0);
        default:             bad = 1;
      endcase
      m_ret = matched && is_this && !bad;
      m_flt = matched && is_this && bad;
      nf = flags_we ? flags_wdata : m_flags;
      if (m_ret) nf[18] = 1'b0;
      m_flags = nf;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "retire", {31'b0, retire}, {31'b0, m_ret});
      chk(cur_req, "fault",  {31'b0, fault},  {31'b0, m_flt});
      chk(cur_req, "flags",  flags_q, m_flags);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input logic v, input logic [7:0] b, input logic lk, input logic md,
                       input logic [1:0] c, input logic [2:0] m, input logic fe);
    @(negedge clk);
    byte_valid = v; byte_in = b; pfx_lock = lk; pfx_mand = md;
    cpl = c; cpu_mode = m; feat_en = fe; flags_we = 1'b0;
  endtask

  task automatic insn(input string tag, input logic lk, input logic md, input logic [1:0] c,
                      input logic [2:0] m, input logic fe, input logic er, input logic ef);
    cur_req = tag;
    drive(1, 8'h0F, lk, md, c, m, fe);
    drive(1, 8'h01, lk, md, c, m, fe);
    drive(1, 8'hCA, lk, md, c, m, fe);
    drive(0, 8'h00, 0, 0, 0, 3'd0, 1);
    chk(tag, "retire pulse", {31'b0, retire}, {31'b0, er});
    chk(tag, "fault pulse",  {31'b0, fault},  {31'b0, ef});
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    byte_valid = 0; flags_we = 1; flags_wdata = v;
    @(negedge clk);
    flags_we = 0;
    chk("R10", "write load", flags_q, v);
  endtask

  task automatic seq_bytes(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input logic er);
    cur_req = tag;
    drive(1, b0, 0, 0, 0, 3'd1, 1);
    drive(1, b1, 0, 0, 0, 3'd1, 1);
    drive(1, b2, 0, 0, 0, 3'd1, 1);
    drive(1, b3, 0, 0, 0, 3'd1, 1);
    drive(0, 8'h00, 0, 0, 0, 3'd1, 1);
    chk(tag, "match result", {31'b0, retire}, {31'b0, er});
  endtask

  initial begin
    // R10 reset value
    repeat (3) @(negedge clk);
    chk("R10", "reset flags", flags_q, 32'h0000_0002);
    chk("R10", "reset retire", {31'b0, retire}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "flags after release", flags_q, 32'h0000_0002);

    // R6: real mode ignores privilege level
    wr(32'hFFFF_FFFF);
    insn("R6", 0, 0, 2'd3, 3'd0, 1, 1, 0);
    chk("R6", "AC cleared in real mode", flags_q, 32'hFFFB_FFFF);

    // R2: legal in protected mode, other bits kept
    wr(32'h0004_0A55);
    insn("R2", 0, 0, 2'd0, 3'd1, 1, 1, 0);
    chk("R2", "only AC cleared", flags_q, 32'h0000_0A55);

    // R5: privilege faults
    wr(32'h0004_0002);
    insn("R5", 0, 0, 2'd1, 3'd1, 1, 0, 1);
    chk("R5", "flags kept on fault", flags_q, 32'h0004_0002);
    insn("R5", 0, 0, 2'd3, 3'd3, 1, 0, 1);
    insn("R5", 0, 0, 2'd2, 3'd4, 1, 0, 1);
    insn("R5", 0, 0, 2'd0, 3'd4, 1, 1, 0);
    chk("R5", "64-bit level 0 clears", flags_q, 32'h0000_0002);

    // R4: LOCK in every mode
    for (int m = 0; m < 5; m++) begin
      wr(32'h0004_0002);
      insn("R4", 1, 0, 2'd0, 3'(m), 1, 0, 1);
      chk("R4", "flags kept under LOCK", flags_q, 32'h0004_0002);
    end

    // R8: feature disabled
    insn("R8", 0, 0, 2'd0, 3'd1, 0, 0, 1);
    insn("R8", 0, 0, 2'd3, 3'd0, 0, 0, 1);

    // R7: virtual-8086 always faults
    insn("R7", 0, 0, 2'd0, 3'd2, 1, 0, 1);
    insn("R7", 0, 1, 2'd3, 3'd2, 1, 0, 1);

    // R3: mandatory prefix means another instruction
    insn("R3", 0, 1, 2'd0, 3'd1, 1, 0, 0);
    chk("R3", "flags untouched", flags_q, 32'h0004_0002);
    insn("R3", 1, 1, 2'd3, 3'd4, 0, 0, 0);

    // R9: several causes, one fault
    insn("R9", 1, 0, 2'd3, 3'd3, 0, 0, 1);
    drive(0, 8'h00, 0, 0, 0, 3'd0, 1);
    chk("R9", "fault lasts one cycle", {31'b0, fault}, 32'h0);

    // R11: unused mode codes
    for (int m = 5; m < 8; m++) insn("R11", 0, 0, 2'd0, 3'(m), 1, 0, 1);

    // R1: matcher orderings
    wr(32'h0004_0002);
    seq_bytes("R1", 8'h0F, 8'h0F, 8'h01, 8'hCA, 1);
    wr(32'h0004_0002);
    seq_bytes("R1", 8'h0F, 8'h05, 8'h01, 8'hCA, 0);
    seq_bytes("R1", 8'h0F, 8'h01, 8'h01, 8'hCA, 0);
    seq_bytes("R1", 8'h0F, 8'h01, 8'h0F, 8'h01, 0);
    drive(1, 8'hCA, 0, 0, 0, 3'd1, 1);
    drive(0, 8'h00, 0, 0, 0, 3'd1, 1);
    chk("R1", "restart after 0F", {31'b0, retire}, 32'h1);
    // idle gaps between bytes keep the partial match
    cur_req = "R1";
    drive(1, 8'h0F, 0, 0, 0, 3'd1, 1);
    drive(0, 8'hCA, 0, 0, 0, 3'd1, 1);
    drive(1, 8'h01, 0, 0, 0, 3'd1, 1);
    drive(0, 8'h33, 0, 0, 0, 3'd1, 1);
    drive(1, 8'hCA, 1, 0, 0, 3'd1, 1);
    drive(0, 8'h00, 0, 0, 0, 3'd1, 1);
    chk("R1", "context sampled at last byte", {31'b0, fault}, 32'h1);

    // R10: write on the same edge as a clear
    cur_req = "R10";
    drive(1, 8'h0F, 0, 0, 0, 3'd1, 1);
    drive(1, 8'h01, 0, 0, 0, 3'd1, 1);
    drive(1, 8'hCA, 0, 0, 0, 3'd1, 1);
    flags_we = 1; flags_wdata = 32'hFFFF_FFFF;
    drive(0, 8'h00, 0, 0, 0, 3'd1, 1);
    chk("R10", "write with clear", flags_q, 32'hFFFB_FFFF);
    // write on the same edge as a fault is taken as is
    drive(1, 8'h0F, 0, 0, 1, 3'd1, 1);
    drive(1, 8'h01, 0, 0, 1, 3'd1, 1);
    drive(1, 8'hCA, 0, 0, 1, 3'd1, 1);
    flags_we = 1; flags_wdata = 32'h0004_1234;
    drive(0, 8'h00, 0, 0, 0, 3'd1, 1);
    chk("R10", "write with fault", flags_q, 32'h0004_1234);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule